// File: doc/BRIEF.md
# Batched Accumulator-to-Byte-Stream Bridge

The bridge moves 32-bit accumulator results out of a slow accumulator clock domain and emits them, one byte per beat, as an 8-bit AXI4-Stream in a faster network clock domain. Software-free control is pulse driven. A one-cycle start pulse latches the number of words for the run. The bridge then pulls data from the producer one batch at a time. A full batch is 256 words, which fills one 1024-byte packet. The last batch of a run is cut down to the words still owed.

Every packet is gated by a permission exchange with the network side. The bridge raises a one-cycle send request while the link reports itself idle. It then holds the stream quiet until `m_axis_tready` comes high as the grant. Bytes leave least significant first, and the last byte of every packet carries `m_axis_tlast`. All data crosses the clock boundary through an asynchronous FIFO with Gray-coded pointers. A word leaves the FIFO only when its fourth byte is accepted. Once every byte of the run has drained, a done flag rises in the accumulator domain.

Top module: `acc2byte_bridge`

## Requirements
- R1: Each stored word leaves as four beats in the order bits 7:0, 15:8, 23:16, 31:24.
- R2: `m_axis_tlast` is 1 exactly on the 1024th byte of each full packet and on the final byte of a run (short last packet), and 0 on every other accepted byte.
- R3: `batch_pull` is a one-cycle pulse. It is issued only while words of the run are still owed, no earlier batch is still being taken in, and the FIFO holds at most depth minus 256 words. A run of N words produces ceil(N/256) pulses.
- R4: After a pulse the bridge stores only the next min(owed, 256) words that come with `acc_word_vld`. Valid words beyond that count, or with no batch open, are ignored and never reach the stream.
- R5: A start with a word count of zero raises `run_done` on the next clock, with no batch pulse and no network traffic.
- R6: `send_req` is a one-cycle pulse that is raised only if `link_idle` was high in the cycle before. There is exactly one pulse per packet. `m_axis_tvalid` stays low from that pulse until `m_axis_tready` has been seen high.
- R7: While `m_axis_tvalid` is high and `m_axis_tready` is low, the valid, data and last outputs hold their values into the next cycle.
- R8: An accepted start clears `run_done` on the next clock. `run_done` rises again only after all 4·N bytes have been accepted, and it then stays high until the next accepted start.
- R9: A start pulse that comes while a run is in progress is ignored: the byte count and data of the run do not change.
- R10: While either reset is low, `run_done`, `batch_pull`, `send_req` and `m_axis_tvalid` are 0.
- R11: The FIFO is never written while full and never read while empty. Under producer bursts and output back-pressure, every byte arrives exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_clk | input | 1 | Accumulator-domain clock |
| acc_rst_n | input | 1 | Accumulator-domain reset, active low, asynchronous assert |
| run_start | input | 1 | One-cycle pulse that starts a run |
| run_words | input | 32 | Number of 32-bit words in the run, latched with `run_start` |
| acc_word | input | 32 | Accumulator result word |
| acc_word_vld | input | 1 | Strobe marking `acc_word` as valid |
| batch_pull | output | 1 | One-cycle request for the next batch of words |
| run_done | output | 1 | Run complete; held until the next accepted start |
| net_clk | input | 1 | Network-domain clock |
| net_rst_n | input | 1 | Network-domain reset, active low, asynchronous assert |
| link_idle | input | 1 | Network side can accept a send request |
| send_req | output | 1 | One-cycle request for permission to send one packet |
| m_axis_tdata | output | 8 | Stream byte |
| m_axis_tvalid | output | 1 | Stream byte valid |
| m_axis_tready | input | 1 | Stream accept; its first high after `send_req` is the grant |
| m_axis_tlast | output | 1 | Last byte of a packet |

## Verification
The two activities that overlap in time are the producer writing a batch into the FIFO and the network side draining the previous packet from it. The accumulator side fills faster than the stream empties, so the room gate for the next batch pull is exercised alongside the pops. Runs of 256, 513 and 700 words, plus random lengths, are used. A byte-exact scoreboard checks the output while tready is stalled at random and stray producer strobes are injected. It also checks that the FIFO never held more than depth minus 256 words when a pull was issued. The same runs check that the last short packet and the done flag both close out at the correct byte.

// File: rtl/bridge_pkg.sv
`timescale 1ns / 1ps
package bridge_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ASK   = 2'd1,
    TX_GRANT = 2'd2,
    TX_SEND  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/bridge_afifo.sv
`timescale 1ns / 1ps
module bridge_afifo #(
  parameter int unsigned DW = 33,
  parameter int unsigned AW = 9
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [AW:0]   wr_used,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wbin_n, wgray, rq1, rq2, rq2_bin;
  logic [PW-1:0] rbin, rbin_n, rgray, wq1, wq2;

  // write side
  always_comb wbin_n = wbin + PW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_en) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_comb begin
    for (int i = 0; i < int'(PW); i++) rq2_bin[i] = ^(rq2 >> i);
  end

  assign wr_used = wbin - rq2_bin;

  // read side
  always_comb rbin_n = rbin + PW'(1);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_en) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end

  assign rd_data  = mem[rbin[AW-1:0]];
  assign rd_empty = (rgray == wq2);

  // R11
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en |-> (wr_used < PW'(DEPTH)));

  // R11
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en |-> !rd_empty);
endmodule

// File: rtl/bridge_acc_ctrl.sv
`timescale 1ns / 1ps
module bridge_acc_ctrl #(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned BATCH_WORDS = 256,
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned UW          = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic [CNT_W-1:0]  run_words,
  input  logic [WORD_W-1:0] acc_word,
  input  logic              acc_word_vld,
  input  logic [UW-1:0]     used,
  output logic              batch_pull,
  output logic              run_done,
  output logic              wr_en,
  output logic [WORD_W:0]   wr_data
);
  localparam int unsigned BL_W = $clog2(BATCH_WORDS + 1);
  localparam logic [UW-1:0]    ROOM_MAX = UW'(DEPTH - BATCH_WORDS);
  localparam logic [CNT_W-1:0] BATCH_C  = CNT_W'(BATCH_WORDS);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             pull_q, pull_n;
  logic [CNT_W-1:0] remain_q, remain_n;
  logic [BL_W-1:0]  left_q, left_n, take;

  assign take    = (remain_q < BATCH_C) ? BL_W'(remain_q) : BL_W'(BATCH_WORDS);
  assign wr_en   = busy_q && acc_word_vld && (left_q != '0);
  assign wr_data = {left_q == BL_W'(1), acc_word};

  always_comb begin
    busy_n   = busy_q;
    done_n   = done_q;
    pull_n   = 1'b0;
    remain_n = remain_q;
    left_n   = left_q;
    if (!busy_q) begin
      if (run_start) begin
        if (run_words == '0) begin
          done_n = 1'b1;
        end else begin
          busy_n   = 1'b1;
          done_n   = 1'b0;
          remain_n = run_words;
        end
      end
    end else begin
      if (wr_en) left_n = left_q - BL_W'(1);
      if (left_q == '0 && remain_q != '0 && used <= ROOM_MAX) begin
        pull_n   = 1'b1;
        left_n   = take;
        remain_n = remain_q - CNT_W'(take);
      end else if (left_q == '0 && remain_q == '0 && used == '0) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pull_q   <= 1'b0;
      remain_q <= '0;
      left_q   <= '0;
    end else begin
      busy_q   <= busy_n;
      done_q   <= done_n;
      pull_q   <= pull_n;
      remain_q <= remain_n;
      left_q   <= left_n;
    end
  end

  assign batch_pull = pull_q;
  assign run_done   = done_q;

  // R3
  pull_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batch_pull |=> !batch_pull);

  // R3
  pull_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batch_pull |-> (used <= ROOM_MAX));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> (!batch_pull && !wr_en));
endmodule

// File: rtl/bridge_net_tx.sv
`timescale 1ns / 1ps
module bridge_net_tx
  import bridge_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W:0]   rd_data,
  input  logic              rd_empty,
  output logic              rd_en,
  input  logic              link_idle,
  output logic              send_req,
  output logic [BYTE_W-1:0] m_axis_tdata,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic              m_axis_tlast
);
  localparam int unsigned LANES = WORD_W / BYTE_W;
  localparam int unsigned LW    = $clog2(LANES);

  tx_state_t       state_q, state_n;
  logic [LW-1:0]   lane_q, lane_n;
  logic            ask_q, ask_n;
  logic            lane_end, beat;
  logic [BYTE_W-1:0] lane_byte [LANES];

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign lane_byte[g] = rd_data[g*BYTE_W +: BYTE_W];
  end

  assign lane_end      = (lane_q == LW'(LANES - 1));
  assign m_axis_tvalid = (state_q == TX_SEND) && !rd_empty;
  assign m_axis_tdata  = lane_byte[lane_q];
  assign m_axis_tlast  = rd_data[WORD_W] && lane_end;
  assign beat          = m_axis_tvalid && m_axis_tready;
  assign rd_en         = beat && lane_end;
  assign send_req      = ask_q;

  always_comb begin
    state_n = state_q;
    lane_n  = lane_q;
    ask_n   = 1'b0;
    unique case (state_q)
      TX_IDLE:  if (!rd_empty) state_n = TX_ASK;
      TX_ASK:   if (link_idle) begin
                  ask_n   = 1'b1;
                  state_n = TX_GRANT;
                end
      TX_GRANT: if (m_axis_tready) state_n = TX_SEND;
      TX_SEND:  if (beat) begin
                  lane_n = lane_end ? '0 : lane_q + LW'(1);
                  if (m_axis_tlast) state_n = TX_IDLE;
                end
      default:  state_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      lane_q  <= '0;
      ask_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      lane_q  <= lane_n;
      ask_q   <= ask_n;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

  // R6
  ask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> $past(link_idle));

  // R6
  ask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> (!m_axis_tvalid && !$past(send_req)));
endmodule

// File: rtl/acc2byte_bridge.sv
`timescale 1ns / 1ps
module acc2byte_bridge #(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned BATCH_WORDS = 256,
  parameter int unsigned FIFO_DEPTH  = 512
) (
  input  logic              acc_clk,
  input  logic              acc_rst_n,
  input  logic              run_start,
  input  logic [CNT_W-1:0]  run_words,
  input  logic [WORD_W-1:0] acc_word,
  input  logic              acc_word_vld,
  output logic              batch_pull,
  output logic              run_done,
  input  logic              net_clk,
  input  logic              net_rst_n,
  input  logic              link_idle,
  output logic              send_req,
  output logic [7:0]        m_axis_tdata,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready,
  output logic              m_axis_tlast
);
  localparam int unsigned AW = $clog2(FIFO_DEPTH);
  localparam int unsigned DW = WORD_W + 1;

  logic          wr_en, rd_en, rd_empty;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW:0]   wr_used;

  bridge_acc_ctrl #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .BATCH_WORDS(BATCH_WORDS),
    .DEPTH(FIFO_DEPTH), .UW(AW + 1)
  ) i_ctrl (
    .clk(acc_clk), .rst_n(acc_rst_n),
    .run_start(run_start), .run_words(run_words),
    .acc_word(acc_word), .acc_word_vld(acc_word_vld),
    .used(wr_used), .batch_pull(batch_pull), .run_done(run_done),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  bridge_afifo #(.DW(DW), .AW(AW)) i_fifo (
    .wr_clk(acc_clk), .wr_rst_n(acc_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .wr_used(wr_used),
    .rd_clk(net_clk), .rd_rst_n(net_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  bridge_net_tx #(.WORD_W(WORD_W)) i_tx (
    .clk(net_clk), .rst_n(net_rst_n),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_en(rd_en),
    .link_idle(link_idle), .send_req(send_req),
    .m_axis_tdata(m_axis_tdata), .m_axis_tvalid(m_axis_tvalid),
    .m_axis_tready(m_axis_tready), .m_axis_tlast(m_axis_tlast)
  );
endmodule

// File: tb/test_acc2byte_bridge.sv
`timescale 1ns / 1ps
module test_acc2byte_bridge;
  localparam int unsigned BATCH = 256;
  localparam int unsigned DEPTH = 512;
  localparam int unsigned PKT_BYTES = BATCH * 4;

  logic        acc_clk = 1'b0, net_clk = 1'b0;
  logic        acc_rst_n, net_rst_n;
  logic        run_start;
  logic [31:0] run_words;
  logic [31:0] acc_word;
  logic        acc_word_vld;
  logic        batch_pull, run_done;
  logic        link_idle, send_req;
  logic [7:0]  m_axis_tdata;
  logic        m_axis_tvalid, m_axis_tready, m_axis_tlast;

  acc2byte_bridge i_acc2byte_bridge (
    .acc_clk(acc_clk), .acc_rst_n(acc_rst_n),
    .run_start(run_start), .run_words(run_words),
    .acc_word(acc_word), .acc_word_vld(acc_word_vld),
    .batch_pull(batch_pull), .run_done(run_done),
    .net_clk(net_clk), .net_rst_n(net_rst_n),
    .link_idle(link_idle), .send_req(send_req),
    .m_axis_tdata(m_axis_tdata), .m_axis_tvalid(m_axis_tvalid),
    .m_axis_tready(m_axis_tready), .m_axis_tlast(m_axis_tlast)
  );

  always #2 net_clk = ~net_clk;   // 250 MHz
  always #7 acc_clk = ~acc_clk;   // unrelated, slower

  int unsigned n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  int unsigned prod_rem = 0, n_pulls = 0, n_asks = 0;
  int unsigned bytes_rcv = 0, pkt_bytes = 0, exp_total = 0, byte_idx = 0;
  bit          prod_busy = 0, stray_en = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned packets_for(input int unsigned words);
    return (words + BATCH - 1) / BATCH;
  endfunction

  // producer: answers each pull with a full 256-word burst
  initial begin
    acc_word = '0;
    acc_word_vld = 1'b0;
    forever begin
      @(negedge acc_clk);
      acc_word_vld = 1'b0;
      if (acc_rst_n && batch_pull) begin
        int unsigned n;
        n = (prod_rem < BATCH) ? prod_rem : BATCH;
        chk(prod_rem != 0, "R3 pull only with words owed", prod_rem, 1);
        chk(exp_q.size() <= DEPTH - BATCH, "R3 pull only with room", exp_q.size(), DEPTH - BATCH);
        n_pulls++;
        prod_busy = 1'b1;
        for (int k = 0; k < int'(BATCH); k++) begin
          logic [31:0] w;
          w = $urandom;
          if (k > 0) chk(!batch_pull, "R3 single pulse, none during batch", batch_pull, 0);
          acc_word = w;
          acc_word_vld = 1'b1;
          if (k < int'(n)) exp_q.push_back(w);
          @(negedge acc_clk);
        end
        acc_word_vld = 1'b0;
        prod_rem -= n;
        prod_busy = 1'b0;
      end else if (stray_en && ($urandom % 6 == 0)) begin
        acc_word = $urandom;     // R4: must be ignored
        acc_word_vld = 1'b1;
      end
    end
  end

  // network side: grant, back-pressure and scoreboard
  initial begin
    bit          in_pkt, wait_grant, prev_stall;
    int unsigned gdelay;
    logic [7:0]  prev_data;
    in_pkt = 0; wait_grant = 0; prev_stall = 0; gdelay = 0; prev_data = '0;
    m_axis_tready = 1'b0;
    link_idle = 1'b0;
    forever begin
      @(negedge net_clk);
      if (!net_rst_n) begin
        in_pkt = 0; wait_grant = 0; prev_stall = 0;
        m_axis_tready = 1'b0;
        link_idle = 1'b0;
        continue;
      end
      if (prev_stall)
        chk(m_axis_tvalid && m_axis_tdata == prev_data, "R7 stalled byte held",
            m_axis_tdata, prev_data);
      if (!in_pkt) chk(!m_axis_tvalid, "R6 no data before grant", m_axis_tvalid, 0);
      if (send_req) begin
        chk(link_idle, "R6 ask only after link idle", link_idle, 1);
        chk(!wait_grant && !in_pkt, "R6 one ask per packet", wait_grant | in_pkt, 0);
        n_asks++;
        wait_grant = 1;
        gdelay = $urandom % 4;
      end
      link_idle = ($urandom % 4) != 0;
      if (in_pkt) m_axis_tready = ($urandom % 4) != 0;
      else if (wait_grant) begin
        if (gdelay == 0) begin
          m_axis_tready = 1'b1;
          in_pkt = 1;
          wait_grant = 0;
        end else begin
          gdelay--;
          m_axis_tready = 1'b0;
        end
      end else m_axis_tready = 1'b0;
      prev_stall = m_axis_tvalid && !m_axis_tready;
      prev_data = m_axis_tdata;
      if (m_axis_tvalid && m_axis_tready) begin
        logic [31:0] w;
        bit is_end;
        if (exp_q.size() == 0) begin
          chk(0, "R4 byte with no owed word", m_axis_tdata, 0);
        end else begin
          w = exp_q[0] >> (8 * byte_idx);
          chk(m_axis_tdata == w[7:0], "R1 R11 byte value and order", m_axis_tdata, w[7:0]);
          is_end = (pkt_bytes + 1 == PKT_BYTES) || (bytes_rcv + 1 == exp_total);
          chk(m_axis_tlast == is_end, "R2 tlast placement", m_axis_tlast, is_end);
          bytes_rcv++;
          pkt_bytes = is_end ? 0 : pkt_bytes + 1;
          if (byte_idx == 3) begin
            byte_idx = 0;
            void'(exp_q.pop_front());
          end else byte_idx++;
        end
        if (m_axis_tlast) in_pkt = 0;
      end
    end
  end

  task automatic run_case(input int unsigned cnt, input bit stray, input bit inject);
    int unsigned pk;
    pk = packets_for(cnt);
    wait (!prod_busy);
    @(negedge acc_clk);
    stray_en = stray;
    prod_rem = cnt; exp_total = cnt * 4;
    bytes_rcv = 0; pkt_bytes = 0; byte_idx = 0; n_asks = 0; n_pulls = 0;
    run_words = cnt;
    run_start = 1'b1;
    @(negedge acc_clk);
    run_start = 1'b0;
    run_words = $urandom;
    if (cnt == 0) begin
      chk(run_done, "R5 zero count done at once", run_done, 1);
      repeat (40) @(negedge acc_clk);
      chk(n_pulls == 0, "R5 zero count pulls", n_pulls, 0);
      chk(n_asks == 0 && bytes_rcv == 0, "R5 zero count traffic", n_asks + bytes_rcv, 0);
      stray_en = 0;
      return;
    end
    chk(!run_done, "R8 done cleared by start", run_done, 0);
    if (inject) begin
      repeat (25) @(negedge acc_clk);
      run_words = 3;            // R9: busy, must be ignored
      run_start = 1'b1;
      @(negedge acc_clk);
      run_start = 1'b0;
    end
    while (!run_done) @(negedge acc_clk);
    chk(bytes_rcv == cnt * 4, "R8 R9 all bytes before done", bytes_rcv, cnt * 4);
    chk(exp_q.size() == 0, "R8 nothing left owed at done", exp_q.size(), 0);
    chk(n_pulls == pk, "R3 pulls per run", n_pulls, pk);
    chk(n_asks == pk, "R6 asks per run", n_asks, pk);
    repeat (12) @(negedge acc_clk);
    chk(run_done, "R8 done holds", run_done, 1);
    stray_en = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    acc_rst_n = 1'b0; net_rst_n = 1'b0;
    run_start = 1'b0; run_words = '0;
    repeat (4) @(negedge acc_clk);
    chk(!run_done && !batch_pull, "R10 acc outputs in reset", {run_done, batch_pull}, 0);
    chk(!send_req && !m_axis_tvalid, "R10 net outputs in reset", {send_req, m_axis_tvalid}, 0);
    @(negedge net_clk) net_rst_n = 1'b1;
    @(negedge acc_clk) acc_rst_n = 1'b1;
    repeat (3) @(negedge acc_clk);
    chk(!run_done && !batch_pull, "R10 idle after reset", {run_done, batch_pull}, 0);

    run_case(0, 0, 0);
    run_case(5, 0, 0);
    run_case(256, 0, 0);
    run_case(700, 1, 1);
    run_case(0, 0, 0);
    run_case(513, 1, 0);
    for (int r = 0; r < 2; r++) run_case($urandom_range(1, 1200), r[0], !r[0]);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge net_clk);
    if (!finished) begin
      chk(0, "R8 watchdog, run never completed", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule